// File: doc/BRIEF.md
# Bit-Serial Save EEPROM

This block models a save-data EEPROM that a host reaches one bit per bus access. Each write access carries a single bit and each read access returns a single bit. A transaction opens with a two-bit command, then a block address. A read request then gets a serial reply; a write request is followed by 64 data bits. Storage is organised as 8-byte blocks held in an internal array. A plain byte port gives the host direct access to that array, for preloading or inspecting save data. An address-size select picks a small device (6-bit block address) or a large device (14-bit block address).

Both serial directions are streams. The incoming bit stream (`cmd_*`) completes an access only in a cycle where `cmd_valid` and `cmd_ready` are both high. The outgoing bit stream (`rsp_*`) completes an access in a cycle where `rsp_valid` and `rsp_ready` are both high. `rsp_valid` is high at all times out of reset, so a read access is never refused. A read access has priority. While `rsp_ready` is high, `cmd_ready` is held low, so the host's write bit waits until no read is being taken. A source may hold `cmd_valid` and `cmd_bit` for any number of cycles. `rsp_bit` is valid in every cycle and moves on only after a completed read access.

Top module: `eep_serial_save`

## Requirements
- R1: The command is two bits, first bit most significant. Code 2'b11 starts a read and 2'b10 starts a write. Codes 2'b00 and 2'b01 leave the block waiting for a fresh command, so that the next two bits form a new command.
- R2: The address is sent most significant bit first. It is 6 bits when `wide_addr` is 0 and 14 bits when it is 1, and `wide_addr` is sampled when the command completes. The array holds 64 blocks indexed by the low 6 bits of the address, so a large-device address aliases to that block.
- R3: After a read address, one extra stop bit is taken and discarded. Its value has no effect on which block is read.
- R4: Storage is little-endian: byte k of a block sits at `st_addr` = {block[5:0], k[2:0]} and holds data bits 8k+7..8k. `st_rdata` shows the addressed byte combinationally. A byte written with `st_we` is visible from the next cycle.
- R5: A read reply is 4 zero bits followed by the 64 stored bits, most significant first, one bit per completed read access. `rsp_bit` stays unchanged while no read access completes.
- R6: After a write address, 64 data bits are taken, and the first bit ends up as bit 63. The block is committed at the edge that takes the 64th bit and is visible on `st_rdata` in the next cycle.
- R7: After a commit, `rsp_bit` is 1 for the next 8 read accesses, and the block then returns to waiting for a command.
- R8: After 68 read accesses the read reply ends and the block waits for a command. While a command, address or write data is being collected, `rsp_bit` is 0 and read accesses change nothing.
- R9: Write accesses during a read reply or a write reply are ignored.
- R10: `cmd_ready` is low in every cycle in which `rsp_ready` is high. Out of reset `rsp_valid` is 1. In reset `rsp_valid` and `rsp_bit` are 0 and no bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_addr | input | 1 | 0: 6-bit address, 1: 14-bit address |
| cmd_valid | input | 1 | Write access offered |
| cmd_ready | output | 1 | Write access can be taken this cycle |
| cmd_bit | input | 1 | Bit carried by the write access |
| rsp_valid | output | 1 | Read bit available |
| rsp_ready | input | 1 | Read access requested |
| rsp_bit | output | 1 | Bit returned to a read access |
| st_we | input | 1 | Direct byte write to storage |
| st_addr | input | 9 | Direct byte address {block, byte} |
| st_wdata | input | 8 | Direct write byte |
| st_rdata | output | 8 | Byte at `st_addr` |

## Verification
The outputs `rsp_bit`, `cmd_ready` and `st_rdata` follow their inputs within the same cycle. The bench therefore sets its inputs on the falling edge and samples 1 ns later, before the rising edge that completes the access. A committed block changes storage at the edge that takes the 64th data bit, so the byte checks run from the following falling edge on. State moves one step per completed access and never on a cycle without a handshake. The bench therefore counts accesses rather than cycles: it expects 4 zeros and 64 data bits from a read reply and 8 ones from a write reply, then a 0 once the block is idle again.

// File: rtl/eep_serial_pkg.sv
package eep_serial_pkg;
  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_RADDR = 3'd1,
    ST_WADDR = 3'd2,
    ST_WDATA = 3'd3,
    ST_RRESP = 3'd4,
    ST_WRESP = 3'd5
  } eep_state_e;
endpackage

// File: rtl/eep_block_store.sv
module eep_block_store #(
  parameter int BLK_BITS    = 64,
  parameter int BLK_DEPTH_W = 6
) (
  input  logic                   clk,
  input  logic [BLK_DEPTH_W-1:0] blk_idx,
  input  logic                   blk_we,
  input  logic [BLK_BITS-1:0]    blk_wdata,
  output logic [BLK_BITS-1:0]    blk_rdata,
  input  logic                   st_we,
  input  logic [BLK_DEPTH_W+$clog2(BLK_BITS/8)-1:0] st_addr,
  input  logic [7:0]             st_wdata,
  output logic [7:0]             st_rdata
);
  localparam int LANES  = BLK_BITS / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int DEPTH  = 1 << BLK_DEPTH_W;

  logic [BLK_DEPTH_W-1:0] st_blk;
  logic [LANE_W-1:0]      st_lane;
  logic [7:0]             st_bytes [LANES];

  assign st_blk  = st_addr[BLK_DEPTH_W+LANE_W-1:LANE_W];
  assign st_lane = st_addr[LANE_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    // byte port first, commit last: commit wins on the same block
    always_ff @(posedge clk) begin
      if (st_we && st_lane == LANE_W'(l)) lane_mem[st_blk] <= st_wdata;
      if (blk_we) lane_mem[blk_idx] <= blk_wdata[8*l +: 8];
    end
    assign blk_rdata[8*l +: 8] = lane_mem[blk_idx];
    assign st_bytes[l]         = lane_mem[st_blk];
  end

  assign st_rdata = st_bytes[st_lane];
endmodule

// File: rtl/eep_bit_ctrl.sv
module eep_bit_ctrl
  import eep_serial_pkg::*;
#(
  parameter int BLK_BITS    = 64,
  parameter int BLK_DEPTH_W = 6,
  parameter int NARROW_AW   = 6,
  parameter int WIDE_AW     = 14,
  parameter int DUMMY_BITS  = 4,
  parameter int WR_BUSY_CNT = 8,
  parameter int CNT_W       = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wide_addr,
  input  logic                   wr_fire,
  input  logic                   wr_bit,
  input  logic                   rd_fire,
  input  logic [BLK_BITS-1:0]    blk_rdata,
  output logic [BLK_DEPTH_W-1:0] blk_idx,
  output logic                   blk_we,
  output logic [BLK_BITS-1:0]    blk_wdata,
  output logic                   rsp_bit,
  output eep_state_e             state_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   cmd_hi_o
);
  localparam logic [CNT_W-1:0] NARROW_C = CNT_W'(NARROW_AW);
  localparam logic [CNT_W-1:0] WIDE_C   = CNT_W'(WIDE_AW);
  localparam logic [CNT_W-1:0] DUMMY_C  = CNT_W'(DUMMY_BITS);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(BLK_BITS - 1);
  localparam logic [CNT_W-1:0] RD_END   = CNT_W'(DUMMY_BITS + BLK_BITS - 1);
  localparam logic [CNT_W-1:0] WB_END   = CNT_W'(WR_BUSY_CNT - 1);
  localparam logic [BLK_DEPTH_W-1:0] NMASK = BLK_DEPTH_W'((64'd1 << NARROW_AW) - 64'd1);
  localparam logic [BLK_DEPTH_W-1:0] WMASK = BLK_DEPTH_W'((64'd1 << WIDE_AW) - 64'd1);

  eep_state_e             state;
  logic [CNT_W-1:0]       cnt;
  logic                   cmd_hi;
  logic                   wide_q;
  logic [BLK_DEPTH_W-1:0] addr_sr;
  logic [BLK_DEPTH_W-1:0] waddr_q;
  logic [BLK_BITS-1:0]    data_sr;

  logic [BLK_DEPTH_W:0]   addr_next;
  logic [CNT_W-1:0]       aw_cur;
  logic [BLK_DEPTH_W-1:0] amask;
  logic [BLK_DEPTH_W-1:0] rd_idx;
  logic [BLK_DEPTH_W-1:0] wr_idx;
  logic [BLK_BITS-1:0]    data_next;

  assign addr_next = {addr_sr, wr_bit};
  assign aw_cur    = wide_q ? WIDE_C : NARROW_C;
  assign amask     = wide_q ? WMASK : NMASK;
  assign rd_idx    = addr_next[BLK_DEPTH_W:1] & amask;   // stop bit dropped
  assign wr_idx    = addr_next[BLK_DEPTH_W-1:0] & amask;
  assign data_next = {data_sr[BLK_BITS-2:0], wr_bit};

  assign blk_idx   = (state == ST_WDATA) ? waddr_q : rd_idx;
  assign blk_we    = (state == ST_WDATA) && wr_fire && (cnt == DATA_END);
  assign blk_wdata = data_next;

  always_comb begin
    unique case (state)
      ST_RRESP: rsp_bit = (cnt < DUMMY_C) ? 1'b0 : data_sr[BLK_BITS-1];
      ST_WRESP: rsp_bit = 1'b1;
      default:  rsp_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      cnt     <= '0;
      cmd_hi  <= 1'b0;
      wide_q  <= 1'b0;
      addr_sr <= '0;
      waddr_q <= '0;
      data_sr <= '0;
    end else begin
      unique case (state)
        ST_CMD: if (wr_fire) begin
          if (cnt == '0) begin
            cmd_hi <= wr_bit;
            cnt    <= CNT_W'(1);
          end else begin
            cnt     <= '0;
            addr_sr <= '0;
            wide_q  <= wide_addr;
            if (cmd_hi && wr_bit)       state <= ST_RADDR;
            else if (cmd_hi && !wr_bit) state <= ST_WADDR;
            else                        state <= ST_CMD;
          end
        end
        ST_RADDR: if (wr_fire) begin
          addr_sr <= addr_next[BLK_DEPTH_W-1:0];
          if (cnt == aw_cur) begin
            data_sr <= blk_rdata;
            cnt     <= '0;
            state   <= ST_RRESP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WADDR: if (wr_fire) begin
          addr_sr <= addr_next[BLK_DEPTH_W-1:0];
          if (cnt == aw_cur - 1'b1) begin
            waddr_q <= wr_idx;
            cnt     <= '0;
            state   <= ST_WDATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WDATA: if (wr_fire) begin
          data_sr <= data_next;
          if (cnt == DATA_END) begin
            cnt   <= '0;
            state <= ST_WRESP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RRESP: if (rd_fire) begin
          if (cnt >= DUMMY_C) data_sr <= {data_sr[BLK_BITS-2:0], 1'b0};
          if (cnt == RD_END) begin
            cnt   <= '0;
            state <= ST_CMD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRESP: if (rd_fire) begin
          if (cnt == WB_END) begin
            cnt   <= '0;
            state <= ST_CMD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_CMD;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign state_o  = state;
  assign cnt_o    = cnt;
  assign cmd_hi_o = cmd_hi;
endmodule

// File: rtl/eep_serial_save.sv
module eep_serial_save
  import eep_serial_pkg::*;
#(
  parameter int BLK_BITS    = 64,
  parameter int BLK_DEPTH_W = 6,
  parameter int NARROW_AW   = 6,
  parameter int WIDE_AW     = 14,
  parameter int DUMMY_BITS  = 4,
  parameter int WR_BUSY_CNT = 8,
  parameter int ST_AW       = BLK_DEPTH_W + $clog2(BLK_BITS / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_addr,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_bit,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_bit,
  input  logic             st_we,
  input  logic [ST_AW-1:0] st_addr,
  input  logic [7:0]       st_wdata,
  output logic [7:0]       st_rdata
);
  localparam int CNT_W = $clog2(DUMMY_BITS + BLK_BITS + WR_BUSY_CNT + WIDE_AW + 2);

  logic                   wr_fire;
  logic                   rd_fire;
  logic                   ctrl_rsp_bit;
  logic [BLK_DEPTH_W-1:0] blk_idx;
  logic                   blk_we;
  logic [BLK_BITS-1:0]    blk_wdata;
  logic [BLK_BITS-1:0]    blk_rdata;
  eep_state_e             state_w;
  logic [CNT_W-1:0]       cnt_w;
  logic                   cmd_hi_w;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= 1'b1;
  end

  assign cmd_ready = !rsp_ready;
  assign wr_fire   = cmd_valid && cmd_ready && rst_n;
  assign rd_fire   = rsp_valid && rsp_ready;
  assign rsp_bit   = rsp_valid && ctrl_rsp_bit;

  eep_bit_ctrl #(
    .BLK_BITS(BLK_BITS), .BLK_DEPTH_W(BLK_DEPTH_W), .NARROW_AW(NARROW_AW),
    .WIDE_AW(WIDE_AW), .DUMMY_BITS(DUMMY_BITS), .WR_BUSY_CNT(WR_BUSY_CNT),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wide_addr(wide_addr),
    .wr_fire(wr_fire), .wr_bit(cmd_bit), .rd_fire(rd_fire),
    .blk_rdata(blk_rdata), .blk_idx(blk_idx), .blk_we(blk_we),
    .blk_wdata(blk_wdata), .rsp_bit(ctrl_rsp_bit),
    .state_o(state_w), .cnt_o(cnt_w), .cmd_hi_o(cmd_hi_w)
  );

  eep_block_store #(.BLK_BITS(BLK_BITS), .BLK_DEPTH_W(BLK_DEPTH_W)) u_store (
    .clk(clk), .blk_idx(blk_idx), .blk_we(blk_we), .blk_wdata(blk_wdata),
    .blk_rdata(blk_rdata), .st_we(st_we), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rdata(st_rdata)
  );
endmodule

// File: rtl/eep_serial_save_chk.sv
module eep_serial_save_chk
  import eep_serial_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int RD_LEN      = 68,
  parameter int WR_BUSY_CNT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_bit,
  input logic             rsp_ready,
  input logic             rsp_valid,
  input logic             rsp_bit,
  input logic             blk_we,
  input eep_state_e       state_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             cmd_hi_w
);
  logic       rd_hs, wr_hs;
  logic [7:0] rr_cnt, wr_cnt;

  assign rd_hs = rsp_valid && rsp_ready;
  assign wr_hs = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      if (state_w == ST_RRESP) rr_cnt <= rr_cnt + (rd_hs ? 8'd1 : 8'd0);
      else                     rr_cnt <= '0;
      if (state_w == ST_WRESP) wr_cnt <= wr_cnt + (rd_hs ? 8'd1 : 8'd0);
      else                     wr_cnt <= '0;
    end
  end

  AST_READ_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !cmd_ready); // R10
  AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_CMD && wr_hs && cnt_w == CNT_W'(1) && !cmd_hi_w) |=> state_w == ST_CMD); // R1
  AST_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_CMD && wr_hs && cnt_w == CNT_W'(1) && cmd_hi_w && cmd_bit) |=> state_w == ST_RADDR); // R1
  AST_COMMIT_TO_WRESP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_we |=> state_w == ST_WRESP); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_RRESP && !rsp_ready) |=> $stable(rsp_bit)); // R5
  AST_RRESP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w != ST_RRESP && $past(state_w) == ST_RRESP) |-> rr_cnt == 8'(RD_LEN)); // R8
  AST_WRESP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w != ST_WRESP && $past(state_w) == ST_WRESP) |-> wr_cnt == 8'(WR_BUSY_CNT)); // R7
  AST_WR_IGNORED_WRESP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_WRESP && !rsp_ready) |=> state_w == ST_WRESP); // R9
endmodule

bind eep_serial_save eep_serial_save_chk #(
  .CNT_W(CNT_W), .RD_LEN(DUMMY_BITS + BLK_BITS), .WR_BUSY_CNT(WR_BUSY_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_bit(cmd_bit), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
  .rsp_bit(rsp_bit), .blk_we(blk_we), .state_w(state_w), .cnt_w(cnt_w),
  .cmd_hi_w(cmd_hi_w)
);

// File: tb/tb_eep_serial_save.sv
`timescale 1ns/1ps
module tb_eep_serial_save;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_addr = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic       cmd_bit = 1'b0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       rsp_bit;
  logic       st_we = 1'b0;
  logic [8:0] st_addr = '0;
  logic [7:0] st_wdata = '0;
  logic [7:0] st_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] model [64];

  always #10 clk = ~clk;

  eep_serial_save dut (
    .clk(clk), .rst_n(rst_n), .wide_addr(wide_addr), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_bit(cmd_bit), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_bit(rsp_bit), .st_we(st_we), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  function automatic logic [5:0] blk_of(input logic [13:0] a, input logic w);
    return w ? a[5:0] : (a[5:0] & 6'h3f);
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic put_bit(input logic b);
    cmd_valid = 1'b1; cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    rsp_ready = 1'b1;
    #1 b = rsp_bit;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic send_addr(input logic [13:0] a, input logic w);
    int n;
    n = w ? 14 : 6;
    for (int i = n - 1; i >= 0; i--) put_bit(a[i]);
  endtask

  task automatic do_write(input logic [13:0] a, input logic w, input logic [63:0] d);
    logic b;
    wide_addr = w;
    put_bit(1'b1); put_bit(1'b0);
    send_addr(a, w);
    for (int i = 63; i >= 0; i--) put_bit(d[i]);
    model[blk_of(a, w)] = d;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      check({63'd0, b}, 64'd1, "R7 write reply ready bit");
    end
    #1 check({63'd0, rsp_bit}, 64'd0, "R7 idle after write reply");
  endtask

  task automatic do_read(input logic [13:0] a, input logic w, input logic stop,
                         output logic [63:0] d);
    logic b;
    wide_addr = w;
    put_bit(1'b1); put_bit(1'b1);
    send_addr(a, w);
    put_bit(stop);
    for (int i = 0; i < 4; i++) begin
      get_bit(b);
      check({63'd0, b}, 64'd0, "R5 dummy zero");
    end
    d = '0;
    for (int i = 0; i < 64; i++) begin
      get_bit(b);
      d = {d[62:0], b};
    end
  endtask

  task automatic rd_byte(input logic [8:0] ad, output logic [7:0] v);
    st_addr = ad;
    #1 v = st_rdata;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] r;
    logic [7:0]  v;
    logic [13:0] a;
    logic        w, b;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    #1;
    check({62'd0, rsp_valid, rsp_bit}, 64'd0, "R10 reset outputs");
    check({63'd0, cmd_ready}, 64'd1, "R10 ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    #1 check({63'd0, rsp_valid}, 64'd1, "R10 rsp_valid out of reset");

    // R4 preload every block through the byte port
    for (int k = 0; k < 64; k++) begin
      model[k] = {$urandom(), $urandom()};
      for (int j = 0; j < 8; j++) begin
        st_we = 1'b1; st_addr = {6'(k), 3'(j)}; st_wdata = model[k][8*j +: 8];
        @(negedge clk);
      end
    end
    st_we = 1'b0;
    rd_byte({6'd9, 3'd5}, v);
    check({56'd0, v}, {56'd0, model[9][47:40]}, "R4 byte port readback");
    do_read(14'd9, 1'b0, 1'b0, r);
    check(r, model[9], "R4 R5 preloaded block read");
    #1 check({63'd0, rsp_bit}, 64'd0, "R8 idle after read reply");

    // R6 serial write, then look at bytes
    d = 64'h0123_4567_89ab_cdef;
    do_write(14'd33, 1'b0, d);
    rd_byte({6'd33, 3'd0}, v);
    check({56'd0, v}, 64'hef, "R6 R4 byte 0 low bits");
    rd_byte({6'd33, 3'd7}, v);
    check({56'd0, v}, 64'h01, "R6 R4 byte 7 high bits");

    // R1 bad command codes then a normal read
    put_bit(1'b0); put_bit(1'b1);
    put_bit(1'b0); put_bit(1'b0);
    do_read(14'd33, 1'b0, 1'b1, r);
    check(r, d, "R1 read after bad codes");

    // R2 wide write aliases to low 6 bits
    d = {$urandom(), $urandom()};
    do_write(14'h2a85, 1'b1, d);
    do_read(14'h0005, 1'b0, 1'b0, r);
    check(r, d, "R2 wide address alias");

    // R8 read access during address collection has no effect
    wide_addr = 1'b0;
    put_bit(1'b1); put_bit(1'b1);
    put_bit(1'b0); put_bit(1'b0);
    get_bit(b);
    check({63'd0, b}, 64'd0, "R8 read during address");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    for (int i = 0; i < 4; i++) get_bit(b);
    r = '0;
    // R9 write accesses during the reply are dropped
    put_bit(1'b1); put_bit(1'b0);
    for (int i = 0; i < 64; i++) begin
      get_bit(b);
      r = {r[62:0], b};
      if (i == 10) begin put_bit(1'b1); put_bit(1'b1); end
    end
    check(r, model[5], "R9 R8 reply intact after ignored writes");
    #1 check({63'd0, rsp_bit}, 64'd0, "R8 back to idle");

    // R10 back-pressure: both requested in the same cycle
    cmd_valid = 1'b1; cmd_bit = 1'b1; rsp_ready = 1'b1;
    #1 check({63'd0, cmd_ready}, 64'd0, "R10 cmd_ready low under read");
    @(negedge clk);
    rsp_ready = 1'b0; cmd_valid = 1'b0;
    do_read(14'd33, 1'b0, 1'b0, r);
    check(r, model[33], "R10 held bit not taken");

    // R2 R3 random mix
    for (int t = 0; t < 50; t++) begin
      w = 1'($urandom());
      a = 14'($urandom());
      if (!w) a[13:6] = '0;
      if ($urandom() % 2 == 0) begin
        d = {$urandom(), $urandom()};
        if (t % 7 == 0) d = (t % 14 == 0) ? '1 : '0;
        do_write(a, w, d);
      end else begin
        do_read(a, w, 1'($urandom()), r);
        check(r, model[blk_of(a, w)], "R2 R3 random read");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule